// File: doc/BRIEF.md
# Brightness Command Mailbox Sequencer

This block runs on the host side of a mailbox to an embedded brightness controller. It turns three kinds of request into fixed scripts of mailbox writes. The requests are a backlight update bound to a display pipe, a dimming-level change, and an immediate disable. The mailbox it drives has four parts: a 32-bit command word split into bytes, a 32-bit data word, a 17-bit user-level word and a doorbell bit. The sequencer sets the doorbell to hand a command over. The receiver clears it through `bell_clr` once it has consumed the command.

A backlight update first writes the ramp boundary and sends a pipe-select command. It then waits for the doorbell to clear. After that it stores the 17-bit level (1 integer bit, 16 fraction bits), writes the frame-ramp value and rings a backlight-set command. In the same step it merges an 8-bit copy of the level into a scratch word. A dimming-level change and a disable both wait for a free doorbell before they write their command. Every wait has a bound. When the bound runs out, the sequencer drops the script and reports an error.

Top module: `bl_mbox_seq`

## Requirements
- R1: After reset the block is idle with `req_ready`=1, `busy`=0, `bell`=0, `done`=0, `err`=0, and `mb_cmd`, `mb_data`, `mb_user` and `scr_out` all zero.
- R2: A request with `req_kind`=0 (backlight) first writes 0x0000FFFF into `mb_data`. It then writes 0x66 into `mb_cmd[7:0]` and the pipe id into `mb_cmd[15:8]`, and sets `bell`.
- R3: After the pipe-select ring, the backlight script holds while `bell` is 1. `mb_user` and `mb_data` stay unchanged until `bell` has been cleared. Only then is the request level written into `mb_user`.
- R4: The backlight script next writes the request's ramp value into `mb_data`. If the pipe id is 0, it writes 0 instead.
- R5: The backlight script ends by writing 0x67 into `mb_cmd[7:0]` (other bytes kept) and setting `bell`. It pulses `done` in the same cycle that `bell` is seen set.
- R6: The backlight script's final step makes `scr_out` equal to `scr_in` with bits [15:8] replaced by an 8-bit shadow and pulses `scr_we`. The shadow is 0xFF when level bit 16 is 1, else level bits [15:8].
- R7: A request with `req_kind`=1 waits until `bell` is 0. It then writes 0x65 into `mb_cmd[7:0]` and `req_dim` into `mb_cmd[23:16]`, keeps byte 1, sets `bell` and pulses `done`.
- R8: A request with `req_kind`=2 or 3 (disable) behaves as R7 with the value 0xFF in `mb_cmd[23:16]`, whatever `req_dim` is.
- R9: If `bell` stays 1 for TIMEOUT cycles of any wait, the block pulses `err` for one cycle and returns to idle. It makes no further mailbox or scratch writes and gives no `done`.
- R10: `req_ready` is low while a script runs, and requests offered then are ignored. Each accepted request gives exactly one `done` or `err` pulse, never both.
- R11: `bell` falls only in the cycle after `bell_clr` was high. A ring made by the block takes priority over a clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_kind | input | 2 | 0 backlight, 1 dimming level, 2/3 disable |
| req_level | input | LVL_W | Backlight level, 1.16 unsigned |
| req_ramp | input | 32 | Frame-ramp value for a backlight update |
| req_pipe | input | 8 | Display pipe id |
| req_dim | input | 8 | Dimming level |
| mb_cmd | output | 32 | Mailbox command word (byte 0 opcode, byte 1 pipe, byte 2 level) |
| mb_data | output | 32 | Mailbox data word |
| mb_user | output | LVL_W | Mailbox user-level word |
| bell | output | 1 | Doorbell bit |
| bell_clr | input | 1 | Receiver clears the doorbell |
| scr_in | input | 32 | Current scratch word |
| scr_out | output | 32 | Scratch word with the shadow level merged in |
| scr_we | output | 1 | Scratch write strobe |
| busy | output | 1 | Script in progress |
| done | output | 1 | Script completed, one-cycle pulse |
| err | output | 1 | Script aborted on timeout, one-cycle pulse |

## Verification
The checker assumes two things about the receiver. It only clears the doorbell through `bell_clr`. It holds `scr_in` steady while a backlight script is in its final step, so the untouched scratch bits can be compared with the previous cycle. The bench plays the receiver. It pulses `bell_clr` for single cycles, and only after it has checked the held state. It also keeps `scr_in` constant for the whole of each request. Requests offered while the block is busy are given with a different kind. They are withdrawn before the script finishes, so any wrongful acceptance would show up as a changed command byte.

// File: rtl/bl_mbox_seq.sv
module bl_mbox_seq #(
  parameter int TIMEOUT    = 80000,
  parameter int LVL_W      = 17,
  parameter int SHADOW_LSB = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_kind,
  input  logic [LVL_W-1:0] req_level,
  input  logic [31:0]      req_ramp,
  input  logic [7:0]       req_pipe,
  input  logic [7:0]       req_dim,
  output logic [31:0]      mb_cmd,
  output logic [31:0]      mb_data,
  output logic [LVL_W-1:0] mb_user,
  output logic             bell,
  input  logic             bell_clr,
  input  logic [31:0]      scr_in,
  output logic [31:0]      scr_out,
  output logic             scr_we,
  output logic             busy,
  output logic             done,
  output logic             err
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LIM = CW'(TIMEOUT - 1);
  localparam logic [7:0] OP_LVL  = 8'h65;
  localparam logic [7:0] OP_PIPE = 8'h66;
  localparam logic [7:0] OP_BL   = 8'h67;
  localparam logic [31:0] FMASK  = 32'hFF << SHADOW_LSB;

  typedef enum logic [2:0] {IDLE, BOUND, PIPE, WPIPE, USER, RAMP, FIN, WLVL} st_t;
  st_t st;

  logic [CW-1:0]    cnt;
  logic [LVL_W-1:0] lvl_q;
  logic [31:0]      ramp_q;
  logic [7:0]       pipe_q, dim_q;
  logic [7:0]       shadow;

  assign req_ready = (st == IDLE);
  assign busy      = ~req_ready;
  assign shadow    = lvl_q[LVL_W-1] ? 8'hFF : lvl_q[LVL_W-2 -: 8];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= IDLE;
      cnt     <= '0;
      lvl_q   <= '0;
      ramp_q  <= '0;
      pipe_q  <= '0;
      dim_q   <= '0;
      mb_cmd  <= '0;
      mb_data <= '0;
      mb_user <= '0;
      bell    <= 1'b0;
      scr_out <= '0;
      scr_we  <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      done   <= 1'b0;
      err    <= 1'b0;
      scr_we <= 1'b0;
      if (bell_clr) bell <= 1'b0;
      case (st)
        IDLE: if (req_valid) begin
          lvl_q  <= req_level;
          ramp_q <= req_ramp;
          pipe_q <= req_pipe;
          dim_q  <= req_kind[1] ? 8'hFF : req_dim;
          cnt    <= '0;
          st     <= (req_kind == 2'd0) ? BOUND : WLVL;
        end
        BOUND: begin
          mb_data <= 32'h0000_FFFF;
          st      <= PIPE;
        end
        PIPE: begin
          mb_cmd[7:0]  <= OP_PIPE;
          mb_cmd[15:8] <= pipe_q;
          bell         <= 1'b1;
          cnt          <= '0;
          st           <= WPIPE;
        end
        WPIPE: begin
          if (!bell) st <= USER;
          else if (cnt == LIM) begin
            err <= 1'b1;
            st  <= IDLE;
          end else cnt <= cnt + 1'b1;
        end
        USER: begin
          mb_user <= lvl_q;
          st      <= RAMP;
        end
        RAMP: begin
          mb_data <= (pipe_q == 8'd0) ? 32'd0 : ramp_q;
          st      <= FIN;
        end
        FIN: begin
          mb_cmd[7:0] <= OP_BL;
          bell        <= 1'b1;
          scr_out     <= (scr_in & ~FMASK) | (32'(shadow) << SHADOW_LSB);
          scr_we      <= 1'b1;
          done        <= 1'b1;
          st          <= IDLE;
        end
        WLVL: begin
          if (!bell) begin
            mb_cmd[7:0]   <= OP_LVL;
            mb_cmd[23:16] <= dim_q;
            bell          <= 1'b1;
            done          <= 1'b1;
            st            <= IDLE;
          end else if (cnt == LIM) begin
            err <= 1'b1;
            st  <= IDLE;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bl_mbox_seq_chk.sv
module bl_mbox_seq_chk #(
  parameter int LVL_W      = 17,
  parameter int SHADOW_LSB = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [LVL_W-1:0] mb_user,
  input logic             bell,
  input logic             bell_clr,
  input logic [31:0]      scr_in,
  input logic [31:0]      scr_out,
  input logic             scr_we,
  input logic             done,
  input logic             err
);
  localparam logic [31:0] FMASK = 32'hFF << SHADOW_LSB;

  // R10
  accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);
  // R10
  done_err_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));
  // R9
  err_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);
  // R9
  err_back_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> req_ready);
  // R5
  done_with_bell_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> bell);
  // R11
  bell_fall_by_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bell) |-> $past(bell_clr));
  // R3
  user_write_bell_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mb_user) |-> !$past(bell));
  // R6
  scratch_keeps_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scr_we |-> ((scr_out & ~FMASK) == ($past(scr_in) & ~FMASK)));
endmodule

bind bl_mbox_seq bl_mbox_seq_chk #(.LVL_W(LVL_W), .SHADOW_LSB(SHADOW_LSB)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .mb_user(mb_user), .bell(bell), .bell_clr(bell_clr), .scr_in(scr_in),
  .scr_out(scr_out), .scr_we(scr_we), .done(done), .err(err));

// File: tb/tb_bl_mbox_seq.sv
module tb_bl_mbox_seq;
  localparam int CLK_PERIOD = 10;
  localparam int TO = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, bell_clr = 1'b0;
  logic [1:0] req_kind = '0;
  logic [16:0] req_level = '0;
  logic [31:0] req_ramp = '0, scr_in = '0;
  logic [7:0] req_pipe = '0, req_dim = '0;
  logic req_ready, bell, scr_we, busy, done, err;
  logic [31:0] mb_cmd, mb_data, scr_out;
  logic [16:0] mb_user;
  int tests = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bl_mbox_seq #(.TIMEOUT(TO)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_level(req_level), .req_ramp(req_ramp),
    .req_pipe(req_pipe), .req_dim(req_dim), .mb_cmd(mb_cmd), .mb_data(mb_data),
    .mb_user(mb_user), .bell(bell), .bell_clr(bell_clr), .scr_in(scr_in),
    .scr_out(scr_out), .scr_we(scr_we), .busy(busy), .done(done), .err(err));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] k, input logic [7:0] p, input logic [16:0] l,
                      input logic [31:0] r, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_pipe = p; req_level = l; req_ramp = r; req_dim = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic ring_clear();
    @(negedge clk) bell_clr = 1'b1;
    @(negedge clk) bell_clr = 1'b0;
  endtask

  task automatic wait_end(output bit gd, output bit ge);
    gd = 0; ge = 0;
    for (int i = 0; i < TO + 40 && !gd && !ge; i++) begin
      @(negedge clk);
      if (done) gd = 1;
      if (err) ge = 1;
    end
  endtask

  task automatic wait_bell();
    for (int i = 0; i < 20 && !bell; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 ready", 32'(req_ready), 1);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 bell", 32'(bell), 0);
    chk("R1 done/err", {30'd0, done, err}, 0);
    chk("R1 regs", mb_cmd | mb_data | 32'(mb_user) | scr_out, 0);
  endtask

  task automatic t_backlight(input logic [7:0] p, input logic [16:0] l, input logic [31:0] r,
                             input logic [31:0] s, input bit leave);
    logic [16:0] prev_user;
    logic [7:0] sh;
    logic [7:0] b2;
    bit gd, ge;
    prev_user = mb_user;
    b2 = mb_cmd[23:16];
    scr_in = s;
    send(2'd0, p, l, r, 8'h00);
    wait_bell();
    chk("R2 boundary", mb_data, 32'h0000FFFF);
    chk("R2 pipe opcode", 32'(mb_cmd[7:0]), 32'h66);
    chk("R2 pipe id", 32'(mb_cmd[15:8]), 32'(p));
    req_valid = 1'b1; req_kind = 2'd1; req_dim = 8'h3C;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R3 user held", 32'(mb_user), 32'(prev_user));
      chk("R3 data held", mb_data, 32'h0000FFFF);
      chk("R10 ready low", 32'(req_ready), 0);
    end
    req_valid = 1'b0;
    ring_clear();
    wait_end(gd, ge);
    chk("R5 done", {30'd0, gd, ge}, 2);
    chk("R5 bl opcode", 32'(mb_cmd[7:0]), 32'h67);
    chk("R5 bell", 32'(bell), 1);
    chk("R4 ramp", mb_data, (p == 0) ? 32'd0 : r);
    chk("R3 user level", 32'(mb_user), 32'(l));
    sh = l[16] ? 8'hFF : l[15:8];
    chk("R6 scratch", scr_out, (s & 32'hFFFF00FF) | (32'(sh) << 8));
    chk("R6 scratch strobe", 32'(scr_we), 1);
    @(negedge clk);
    chk("R10 single done", 32'(done), 0);
    chk("R10 refused request", 32'(mb_cmd[23:16]), 32'(b2));
    if (!leave) begin
      ring_clear();
      chk("R11 bell cleared", 32'(bell), 0);
    end
  endtask

  task automatic t_level(input logic [7:0] d, input bit dis);
    logic [7:0] b1;
    bit gd, ge;
    b1 = mb_cmd[15:8];
    send(dis ? 2'd2 : 2'd1, 8'h00, 17'd0, 32'd0, d);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R7 waits for bell", 32'(mb_cmd[7:0]), 32'h67);
    end
    ring_clear();
    wait_end(gd, ge);
    chk(dis ? "R8 done" : "R7 done", {30'd0, gd, ge}, 2);
    chk("R7 level opcode", 32'(mb_cmd[7:0]), 32'h65);
    chk(dis ? "R8 disable level" : "R7 level byte", 32'(mb_cmd[23:16]), dis ? 32'hFF : 32'(d));
    chk("R7 byte1 kept", 32'(mb_cmd[15:8]), 32'(b1));
    chk("R7 bell", 32'(bell), 1);
    ring_clear();
    chk("R11 bell cleared", 32'(bell), 0);
  endtask

  task automatic t_timeout_level();
    logic [31:0] c;
    bit gd, ge;
    c = mb_cmd;
    send(2'd1, 8'h00, 17'd0, 32'd0, 8'h11);
    wait_end(gd, ge);
    chk("R9 level err", {30'd0, gd, ge}, 1);
    chk("R9 cmd untouched", mb_cmd, c);
    chk("R9 idle", 32'(req_ready), 1);
    @(negedge clk);
    chk("R9 err one cycle", 32'(err), 0);
    chk("R9 no late write", mb_cmd, c);
    ring_clear();
  endtask

  task automatic t_timeout_bl();
    logic [16:0] u;
    bit gd, ge;
    u = mb_user;
    send(2'd0, 8'h09, 17'h0AAAA, 32'h55, 8'h00);
    wait_end(gd, ge);
    chk("R9 bl err", {30'd0, gd, ge}, 1);
    chk("R9 user untouched", 32'(mb_user), 32'(u));
    chk("R9 data still boundary", mb_data, 32'h0000FFFF);
    repeat (3) @(negedge clk);
    chk("R9 no scratch write", 32'(scr_we), 0);
    chk("R9 data after", mb_data, 32'h0000FFFF);
    ring_clear();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_backlight(8'h03, 17'h0EFF0, 32'h20, 32'hA5A5A5A5, 0);
    t_backlight(8'h00, 17'h10000, 32'h1234, 32'hFFFF0000, 1);
    t_level(8'h40, 0);
    t_backlight(8'h05, 17'h00180, 32'h7, 32'h0, 1);
    t_level(8'h22, 1);
    t_backlight(8'h02, 17'h08000, 32'h99, 32'h12345678, 1);
    t_timeout_level();
    t_timeout_bl();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule